// File: doc/BRIEF.md
# I2C Memory Slave Front End

This block is the bus-facing half of an I2C target that sits in front of a small on-chip nonvolatile store. It brings SCL and SDA from an open-drain bus into the system clock domain and recognises start and stop conditions. It collects the first byte of each transfer and compares it with the slave address. After that it either passes received bytes to the memory side or fetches bytes from the memory side and shifts them out. It answers the acknowledge slot itself. SDA is driven only through a pull-low enable.

The slave address has two parts. The upper four bits are a build-time parameter. The next three bits come from device-select pins, so several identical parts can share one bus. While the memory reports an internally timed erase or write, the front end refuses every new transfer by leaving the acknowledge slot high.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset the SDA pull enable, the write strobe and the read request are all low.
- R2: SDA falling while SCL is high is a start, and SDA rising while SCL is high is a stop. Either one, at any point, clears the bit count and the match state, and it releases SDA. A start makes the next eight bits the address byte.
- R3: Bits are sampled on SCL rising edges, MSB first. The address matches when byte bits 7..4 equal the parameter ADDR_PREFIX (default 4'b1010) and bits 3..1 equal dev_sel_i[2:0]. Bit 0 set to 1 selects a read (slave transmits) and bit 0 set to 0 selects a write (slave receives).
- R4: To acknowledge, the slave sets sda_pull_o (1 = pull SDA low) at the SCL fall that follows the eighth rising edge. It clears it at the next SCL fall, so SDA stays low for the whole high period of the ninth clock.
- R5: On an address mismatch the slave does not acknowledge. It then drives nothing and reports nothing until the next start or stop.
- R6: If mem_busy_i is high at the eighth rising edge of the address byte, the address is not acknowledged and the transfer is ignored as in R5.
- R7: In a write, at the eighth rising edge of each data byte with mem_busy_i low, wr_valid_o pulses for one clock with wr_data_o holding the byte, and the byte is acknowledged. With mem_busy_i high the byte is not acknowledged, no pulse is given, and the rest of the transfer is ignored.
- R8: In a read, at the SCL fall that ends the acknowledge of the address, and at each SCL fall that ends a master ACK, the slave takes rd_data_i and pulses rd_req_o for one clock. It drives bit 7 of that byte right away and each following bit at the next SCL fall, pulling low for a 0.
- R9: In a read, the slave releases SDA at the SCL fall after the eighth rising edge of each byte. If SDA is high at the ninth rising edge (NACK), it drives nothing more and requests nothing until the next start or stop.
- R10: With the default two synchronizer stages, each output change happens on the third rising clock edge after the SCL or SDA change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL as seen on the bus |
| sda_i | input | 1 | SDA as seen on the bus |
| dev_sel_i | input | 3 | Pin-strapped address bits 3..1 |
| mem_busy_i | input | 1 | Memory is running an internal erase or write |
| rd_data_i | input | 8 | Next byte to transmit in a read |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| wr_valid_o | output | 1 | One-clock strobe for a received data byte |
| wr_data_o | output | 8 | Received data byte |
| rd_req_o | output | 1 | One-clock strobe: rd_data_i was taken, present the next byte |

## Verification
Every result here follows a bus edge by a fixed delay. The pull enable, the write strobe and the read request each change on the third clock edge after the SCL or SDA transition that causes them. The bench writes its expected values in the same half cycle in which it moves a bus line, sends them through its own three-stage delay, and compares on every falling clock edge. Bus edges are spaced eight clocks apart, so every expected change settles before the next one. Acknowledge and read data bits are also checked, on their own, the way a master would see them: in the middle of the SCL high phase.

// File: rtl/i2c_slv_pkg.sv
`timescale 1ns/1ps
package i2c_slv_pkg;
  localparam int BYTE_W = 8;
  localparam int PFX_W  = 4;
  localparam int SEL_W  = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_SETUP,
    ST_ACK_HOLD,
    ST_WR,
    ST_RD,
    ST_RD_ACK,
    ST_RD_NEXT,
    ST_IGNORE
  } slv_state_e;
endpackage

// File: rtl/i2c_bus_sync.sv
`timescale 1ns/1ps
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int NL = 2;  // [1] scl, [0] sda

  logic [NL-1:0] line_in, line_s, line_q;
  assign line_in = {scl_i, sda_i};

  for (genvar g = 0; g < NL; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[STAGES-2:0], line_in[g]};
    end
    assign line_s[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= '1;
    else         line_q <= line_s;
  end

  assign scl_o      = line_s[1];
  assign sda_o      = line_s[0];
  assign scl_rise_o = line_s[1] & ~line_q[1];
  assign scl_fall_o = ~line_s[1] & line_q[1];
  // conditions need SCL high on both samples around the SDA edge
  assign start_o    = line_s[1] & line_q[1] & line_q[0] & ~line_s[0];
  assign stop_o     = line_s[1] & line_q[1] & ~line_q[0] & line_s[0];
endmodule

// File: rtl/i2c_addr_match.sv
`timescale 1ns/1ps
module i2c_addr_match
  import i2c_slv_pkg::*;
#(
  parameter logic [PFX_W-1:0] ADDR_PREFIX = 4'b1010
) (
  input  logic [BYTE_W-1:1] addr_i,
  input  logic [SEL_W-1:0]  dev_sel_i,
  output logic              hit_o
);
  localparam int SEL_LO = 1;
  localparam int SEL_HI = SEL_LO + SEL_W - 1;
  localparam int PFX_LO = SEL_HI + 1;

  logic pfx_ok, sel_ok;
  assign pfx_ok = (addr_i[BYTE_W-1:PFX_LO] == ADDR_PREFIX);
  assign sel_ok = (addr_i[SEL_HI:SEL_LO] == dev_sel_i);
  assign hit_o  = pfx_ok & sel_ok;
endmodule

// File: rtl/i2c_slave_ctrl.sv
`timescale 1ns/1ps
module i2c_slave_ctrl
  import i2c_slv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_hit_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              sda_pull_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_req_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

  slv_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic              pull_q, rd_mode_q;

  assign rx_byte_o  = {rx_q[BYTE_W-2:0], sda_s_i};
  assign sda_pull_o = pull_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      pull_q     <= 1'b0;
      rd_mode_q  <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_data_o  <= '0;
      rd_req_o   <= 1'b0;
    end else begin
      wr_valid_o <= 1'b0;
      rd_req_o   <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        pull_q  <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        pull_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: if (scl_rise_i) begin
            rx_q <= rx_byte_o;
            if (cnt_q == LAST_BIT) begin
              cnt_q <= '0;
              if (addr_hit_i && !busy_i) begin
                rd_mode_q <= rx_byte_o[0];
                state_q   <= ST_ACK_SETUP;
              end else begin
                state_q <= ST_IGNORE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_WR: if (scl_rise_i) begin
            rx_q <= rx_byte_o;
            if (cnt_q == LAST_BIT) begin
              cnt_q <= '0;
              if (busy_i) begin
                state_q <= ST_IGNORE;
              end else begin
                wr_valid_o <= 1'b1;
                wr_data_o  <= rx_byte_o;
                state_q    <= ST_ACK_SETUP;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_ACK_SETUP: if (scl_fall_i) begin
            pull_q  <= 1'b1;
            state_q <= ST_ACK_HOLD;
          end
          ST_ACK_HOLD: if (scl_fall_i) begin
            cnt_q <= '0;
            if (rd_mode_q) begin
              tx_q     <= rd_data_i;
              pull_q   <= ~rd_data_i[BYTE_W-1];
              rd_req_o <= 1'b1;
              state_q  <= ST_RD;
            end else begin
              pull_q  <= 1'b0;
              state_q <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise_i) cnt_q <= cnt_q + 1'b1;
            if (scl_fall_i) begin
              if (cnt_q == FULL) begin
                cnt_q   <= '0;
                pull_q  <= 1'b0;
                state_q <= ST_RD_ACK;
              end else begin
                tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                pull_q <= ~tx_q[BYTE_W-2];
              end
            end
          end
          ST_RD_ACK: if (scl_rise_i) begin
            state_q <= sda_s_i ? ST_IGNORE : ST_RD_NEXT;
          end
          ST_RD_NEXT: if (scl_fall_i) begin
            tx_q     <= rd_data_i;
            pull_q   <= ~rd_data_i[BYTE_W-1];
            rd_req_o <= 1'b1;
            state_q  <= ST_RD;
          end
          default: ;  // idle / ignore: wait for a bus condition
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_slave.sv
`timescale 1ns/1ps
module i2c_mem_slave
  import i2c_slv_pkg::*;
#(
  parameter logic [PFX_W-1:0] ADDR_PREFIX = 4'b1010,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [SEL_W-1:0]  dev_sel_i,
  input  logic              mem_busy_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_pull_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_req_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, cond_start, cond_stop;
  logic addr_hit;
  logic [BYTE_W-1:0] rx_byte;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (cond_start),
    .stop_o     (cond_stop)
  );

  i2c_addr_match #(.ADDR_PREFIX(ADDR_PREFIX)) u_match (
    .addr_i    (rx_byte[BYTE_W-1:1]),
    .dev_sel_i (dev_sel_i),
    .hit_o     (addr_hit)
  );

  i2c_slave_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (cond_start),
    .stop_i     (cond_stop),
    .addr_hit_i (addr_hit),
    .busy_i     (mem_busy_i),
    .rd_data_i  (rd_data_i),
    .rx_byte_o  (rx_byte),
    .sda_pull_o (sda_pull_o),
    .wr_valid_o (wr_valid_o),
    .wr_data_o  (wr_data_o),
    .rd_req_o   (rd_req_o)
  );
endmodule

// File: rtl/i2c_mem_slave_chk.sv
`timescale 1ns/1ps
module i2c_mem_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s_i,
  input logic start_i,
  input logic stop_i,
  input logic sda_pull_i,
  input logic wr_valid_i,
  input logic rd_req_i
);
  a_r7_wr_pulse_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> !wr_valid_i);

  a_r8_rd_pulse_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> !rd_req_i);

  a_r4_pull_set_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_i) |-> !$past(scl_s_i));

  a_r2_cond_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || stop_i) |=> (!sda_pull_i && !wr_valid_i && !rd_req_i));

  a_r7_wr_on_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |-> $past(scl_s_i));

  a_r8_rd_on_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |-> !$past(scl_s_i));
endmodule

bind i2c_mem_slave i2c_mem_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s_i    (scl_s),
  .start_i    (cond_start),
  .stop_i     (cond_stop),
  .sda_pull_i (sda_pull_o),
  .wr_valid_i (wr_valid_o),
  .rd_req_i   (rd_req_o)
);

// File: tb/tb_i2c_mem_slave.sv
`timescale 1ns/1ps
module tb_i2c_mem_slave;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] dev_sel = 3'b101;
  logic       busy = 1'b0;
  logic [7:0] rd_data;
  logic       pull, wr_valid, rd_req;
  logic [7:0] wr_data;
  logic       bus_sda;

  assign bus_sda = sda_m & ~pull;

  i2c_mem_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(bus_sda),
    .dev_sel_i(dev_sel), .mem_busy_i(busy), .rd_data_i(rd_data),
    .sda_pull_o(pull), .wr_valid_o(wr_valid), .wr_data_o(wr_data),
    .rd_req_o(rd_req)
  );

  int tests = 0, fails = 0;
  string cur_req = "R1";

  function automatic logic [7:0] rd_byte(input int i);
    return 8'h3C ^ 8'(i * 37);
  endfunction

  // memory side
  int rd_ptr = 0;
  always @(posedge clk) if (rst_n && rd_req) rd_ptr <= rd_ptr + 1;
  assign rd_data = rd_byte(rd_ptr);

  // expected values, delayed three clocks (R10)
  logic       e_pull = 0, e_wr = 0, e_rd = 0;
  logic [7:0] e_wd = 0;
  logic [2:0] p_pull = 0, p_wr = 0, p_rd = 0;
  logic [7:0] p_wd [3] = '{default: 8'h00};
  always @(posedge clk) begin
    p_pull <= {p_pull[1:0], e_pull};
    p_wr   <= {p_wr[1:0], e_wr};
    p_rd   <= {p_rd[1:0], e_rd};
    p_wd[2] <= p_wd[1]; p_wd[1] <= p_wd[0]; p_wd[0] <= e_wd;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(pull == p_pull[2], cur_req, "sda_pull (R10 timing)", pull, p_pull[2]);
    chk(wr_valid == p_wr[2], cur_req, "wr_valid", wr_valid, p_wr[2]);
    chk(rd_req == p_rd[2], cur_req, "rd_req", rd_req, p_rd[2]);
    if (p_wr[2]) chk(wr_data == p_wd[2], cur_req, "wr_data", wr_data, p_wd[2]);
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  int         e_idx = 0;
  logic [7:0] rd_cur = 0;

  task automatic load_next();
    rd_cur = rd_byte(e_idx);
    e_idx++;
    e_pull = ~rd_cur[7];
    e_rd = 1'b1;
    wclk(1);
    e_rd = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(HALF);
    scl_m = 1'b1; wclk(HALF);
    sda_m = 1'b0; e_pull = 1'b0; wclk(HALF);
    scl_m = 1'b0; wclk(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(HALF);
    scl_m = 1'b1; wclk(HALF);
    sda_m = 1'b1; e_pull = 1'b0; wclk(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit ack, input bit wr,
                           input bit ld, input string req);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(HALF);
      scl_m = 1'b1;
      if (i == 0 && wr) begin e_wr = 1'b1; e_wd = b; end
      wclk(1); e_wr = 1'b0; wclk(2*HALF - 1);
      scl_m = 1'b0;
      if (i == 0) e_pull = ack;
      wclk(HALF);
    end
    sda_m = 1'b1; wclk(HALF);
    scl_m = 1'b1; wclk(HALF);
    chk(bus_sda == !ack, req, "ack slot seen by master", bus_sda, !ack);
    wclk(HALF);
    scl_m = 1'b0;
    if (ld) begin load_next(); wclk(HALF - 1); end
    else begin e_pull = 1'b0; wclk(HALF); end
  endtask

  task automatic recv_byte(input bit mack, input string req);
    logic [7:0] d;
    d = rd_cur;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wclk(HALF);
      scl_m = 1'b1; wclk(HALF);
      chk(bus_sda == d[i], req, "read bit seen by master", bus_sda, d[i]);
      wclk(HALF);
      scl_m = 1'b0;
      e_pull = (i > 0) ? ~d[i-1] : 1'b0;
      wclk(HALF);
    end
    sda_m = mack ? 1'b0 : 1'b1; wclk(HALF);
    scl_m = 1'b1; wclk(2*HALF);
    scl_m = 1'b0;
    if (mack) begin load_next(); wclk(HALF - 1); end
    else wclk(HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wclk(4);
    rst_n = 1'b1;
    wclk(1);
    cur_req = "R1";
    chk(pull == 0, "R1", "pull after reset", pull, 0);
    chk(wr_valid == 0, "R1", "wr_valid after reset", wr_valid, 0);
    chk(rd_req == 0, "R1", "rd_req after reset", rd_req, 0);
    wclk(HALF);

    // matching write, two bytes
    cur_req = "R7";
    bus_start();
    send_byte(8'hAA, 1, 0, 0, "R4");
    send_byte(8'h5A, 1, 1, 0, "R7");
    send_byte(8'hC3, 1, 1, 0, "R7");
    bus_stop();

    // prefix mismatch
    cur_req = "R5";
    bus_start();
    send_byte(8'hBA, 0, 0, 0, "R5");
    send_byte(8'h00, 0, 0, 0, "R5");
    bus_stop();

    // device-select mismatch
    cur_req = "R3";
    bus_start();
    send_byte(8'hA6, 0, 0, 0, "R3");
    send_byte(8'hFF, 0, 0, 0, "R5");
    bus_stop();

    // busy during address
    cur_req = "R6";
    busy = 1'b1;
    bus_start();
    send_byte(8'hAA, 0, 0, 0, "R6");
    send_byte(8'h12, 0, 0, 0, "R6");
    bus_stop();
    busy = 1'b0;

    // busy rises during a write
    cur_req = "R7";
    bus_start();
    send_byte(8'hAA, 1, 0, 0, "R4");
    send_byte(8'h81, 1, 1, 0, "R7");
    busy = 1'b1;
    send_byte(8'h42, 0, 0, 0, "R7");
    busy = 1'b0;
    send_byte(8'h24, 0, 0, 0, "R7");
    bus_stop();

    // read: ACK, ACK, NACK, then nothing more
    cur_req = "R8";
    bus_start();
    send_byte(8'hAB, 1, 0, 1, "R8");
    recv_byte(1, "R8");
    recv_byte(1, "R8");
    cur_req = "R9";
    recv_byte(0, "R9");
    send_byte(8'h00, 0, 0, 0, "R9");
    bus_stop();

    // write, then repeated start into a read
    cur_req = "R2";
    bus_start();
    send_byte(8'hAA, 1, 0, 0, "R2");
    send_byte(8'h11, 1, 1, 0, "R2");
    bus_start();
    send_byte(8'hAB, 1, 0, 1, "R2");
    recv_byte(0, "R9");
    bus_stop();

    // stop in the middle of the address byte, then a clean transfer
    cur_req = "R2";
    bus_start();
    for (int i = 7; i >= 4; i--) begin
      sda_m = 1'(8'hAA >> i); wclk(HALF);
      scl_m = 1'b1; wclk(2*HALF);
      scl_m = 1'b0; wclk(HALF);
    end
    bus_stop();
    bus_start();
    send_byte(8'hAA, 1, 0, 0, "R2");
    send_byte(8'h3E, 1, 1, 0, "R2");
    bus_stop();

    // new device-select strap
    cur_req = "R3";
    dev_sel = 3'b010;
    wclk(HALF);
    bus_start();
    send_byte(8'hAA, 0, 0, 0, "R3");
    bus_stop();
    bus_start();
    send_byte(8'hA4, 1, 0, 0, "R3");
    send_byte(8'h7E, 1, 1, 0, "R3");
    bus_stop();

    wclk(4*HALF);
    cur_req = "R10";
    chk(rd_ptr == e_idx, "R8", "read bytes consumed", rd_ptr, e_idx);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule